// File: doc/BRIEF.md
# DAC Conversion Trigger Controller

This block is the digital front end of a 12-bit digital-to-analog converter. A small register bus reaches five word registers: control, data, software trigger, status and settling delay. The block decides when a conversion starts, extracts the 12-bit code from the data word, and hands a one-cycle start strobe plus the code to the analog core. It tracks the busy window, which models analog settling with a programmable cycle count. It raises the finish and DMA under-run flags and drives one interrupt line.

A conversion can be started by a write to the data register, by a software pulse, by an external pin (level or edge), by one of four timer pulses or by one of two PWM pulses. When DMA is enabled, every accepted hardware trigger raises a request for the next data word. A trigger that arrives while that request is still open is an under-run: the old code is converted again and a flag is set.

The conversion output is a one-way strobe with no ready signal. The analog core cannot push back, and the busy window keeps new starts away until the settling count has run out. The DMA request is a level that stays high until a data write answers it. All bus accesses complete in one cycle, and reads are combinational on the address.

Top module: `dac_trig_ctrl`

## Requirements
- R1: With control bit 1 (trigger enable) at 0, a write to the data register (address 1) while idle gives a `conv_start` pulse of exactly one cycle in the cycle after the write edge. That conversion uses the newly written word.
- R2: With trigger enable at 1 and select field (control bits 7:5) at 0, writing 1 to bit 0 of the software trigger register (address 2) starts exactly one conversion. That bit reads back 0 one cycle later. In this mode, data writes start nothing.
- R3: With trigger enable at 1, select values 2, 3, 4 and 5 choose timer pulses 0 to 3, and values 6 and 7 choose PWM pulses 0 and 1. A pulse on a source that is not selected starts nothing.
- R4: Select value 1 chooses `ext_pin`. The pin goes through a two-flop synchronizer. Control bits 9:8 set the condition: 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. Edge modes convert once per edge, and level modes convert again and again while the level holds.
- R5: Control bit 4 at 0 (right alignment) takes the code from data bits 11:0. At 1 (left alignment) it takes the code from data bits 15:4. All other data bits are ignored.
- R6: After a start, status bit 8 (address 3) reads 1 for exactly D cycles, where D is the delay register (address 4, reset value 1, a value of 0 acts as 1). Triggers that arrive while busy are ignored, although a data write still stores its word.
- R7: Status bit 0 (finish) is set on the edge where the busy count expires. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R8: With control bit 2 (DMA enable) at 1, each accepted hardware trigger (select 1 to 7) raises `dma_req`. The request stays high until a data write.
- R9: An accepted hardware trigger while `dma_req` is still high sets status bit 1 (under-run) and converts the previous code again. Writing 1 to status bit 1 clears it.
- R10: `irq` = (finish AND control bit 0) OR (under-run AND control bit 3).
- R11: After reset, control, status, data and the software trigger register read 0, the delay register reads 1, and `conv_start`, `dma_req` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address: 0 control, 1 data, 2 software trigger, 3 status, 4 delay |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| tmr_pulse | input | N_TMR (4) | Timer trigger pulses |
| pwm_pulse | input | N_PWM (2) | PWM trigger pulses |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_code | output | CODE_W (12) | Code held for the analog core |
| dma_req | output | 1 | Request for the next data word |
| irq | output | 1 | Interrupt line |

## Verification
One data word, 0xABCDE5F7, is converted under both alignments, so the bench can tell bits 11:0 apart from bits 15:4. Every trigger source is pulsed once while selected and once while a neighbour is selected, which exposes any mistake in the select decoding. The pin is driven through both edges in every condition mode, so a single edge can be told from a held level. The DMA sequence fires a trigger with the request answered and one with it left open, which separates a normal reconversion from an under-run.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_DATA  = 3'd1,
    A_SWTRG = 3'd2,
    A_STAT  = 3'd3,
    A_DELAY = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    PIN_LOW  = 2'd0,
    PIN_HIGH = 2'd1,
    PIN_FALL = 2'd2,
    PIN_RISE = 2'd3
  } pin_cond_e;

  // control word, packed MSB first: [9:8] pin cond, [7:5] select,
  // [4] left align, [3] under-run irq en, [2] dma en, [1] trigger en, [0] finish irq en
  typedef struct packed {
    logic [1:0] pin_cond;
    logic [2:0] trig_sel;
    logic       left_align;
    logic       udr_ie;
    logic       dma_en;
    logic       trig_en;
    logic       fin_ie;
  } ctrl_t;

  localparam int unsigned CTRL_W   = $bits(ctrl_t);
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned STAT_FIN = 0;
  localparam int unsigned STAT_UDR = 1;
  localparam int unsigned STAT_BSY = 8;
endpackage

// File: rtl/dac_pin_cond.sv
module dac_pin_cond
  import dac_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_async,
  input  logic [1:0] cond,
  output logic       hit
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    unique case (pin_cond_e'(cond))
      PIN_LOW:  hit = !sync_q;
      PIN_HIGH: hit = sync_q;
      PIN_FALL: hit = prev_q && !sync_q;
      PIN_RISE: hit = !prev_q && sync_q;
      default:  hit = 1'b0;
    endcase
  end

  // an edge hit needs the previous sample to differ from the current one (R4)
  assert_edge_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond[1] && hit) |-> (prev_q != sync_q));
endmodule

// File: rtl/dac_trig_mux.sv
module dac_trig_mux #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned N_TMR = 4,
  parameter int unsigned N_PWM = 2
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             sw_pulse,
  input  logic             pin_hit,
  input  logic [N_TMR-1:0] tmr,
  input  logic [N_PWM-1:0] pwm,
  output logic             evt
);
  localparam int unsigned TMR_BASE = 2;
  localparam int unsigned PWM_BASE = TMR_BASE + N_TMR;

  always_comb begin
    evt = 1'b0;
    if (sel == SEL_W'(0)) evt = sw_pulse;
    if (sel == SEL_W'(1)) evt = pin_hit;
    for (int i = 0; i < N_TMR; i++)
      if (sel == SEL_W'(TMR_BASE + i)) evt = tmr[i];
    for (int j = 0; j < N_PWM; j++)
      if (sel == SEL_W'(PWM_BASE + j)) evt = pwm[j];
  end
endmodule

// File: rtl/dac_conv_seq.sv
module dac_conv_seq #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [CODE_W-1:0] code_in,
  input  logic [DLY_W-1:0]  delay,
  output logic              accept,
  output logic              conv_start,
  output logic [CODE_W-1:0] conv_code,
  output logic              busy,
  output logic              expire
);
  logic [DLY_W-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign accept = trig && !busy;
  assign expire = (cnt_q == DLY_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      conv_start <= 1'b0;
      conv_code  <= '0;
    end else begin
      conv_start <= accept;
      if (accept) begin
        cnt_q     <= (delay == '0) ? DLY_W'(1) : delay;
        conv_code <= code_in;
      end else if (busy) begin
        cnt_q <= cnt_q - DLY_W'(1);
      end
    end
  end

  assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_start_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_trig_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned N_TMR  = 4,
  parameter int unsigned N_PWM  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  ext_pin,
  input  logic [N_TMR-1:0]      tmr_pulse,
  input  logic [N_PWM-1:0]      pwm_pulse,
  output logic                  conv_start,
  output logic [CODE_W-1:0]     conv_code,
  output logic                  dma_req,
  output logic                  irq
);
  localparam int unsigned LA_LSB = 4;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] data_q;
  logic [DLY_W-1:0]  delay_q;
  logic              sw_q, fin_q, udr_q, dma_pend_q;

  logic wr_ctrl, wr_data, wr_sw, wr_stat, wr_dly;
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_sw   = bus_wr && (bus_addr == A_SWTRG);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_dly  = bus_wr && (bus_addr == A_DELAY);

  // source selection
  logic pin_hit, hw_evt, is_hw, start_req;
  dac_pin_cond u_pin (
    .clk(clk), .rst_n(rst_n), .pin_async(ext_pin),
    .cond(ctrl_q.pin_cond), .hit(pin_hit)
  );
  dac_trig_mux #(.SEL_W(SEL_W), .N_TMR(N_TMR), .N_PWM(N_PWM)) u_mux (
    .sel(ctrl_q.trig_sel), .sw_pulse(sw_q), .pin_hit(pin_hit),
    .tmr(tmr_pulse), .pwm(pwm_pulse), .evt(hw_evt)
  );
  assign is_hw     = ctrl_q.trig_en && (ctrl_q.trig_sel != '0);
  assign start_req = ctrl_q.trig_en ? hw_evt : wr_data;

  // code extraction, fresh word when the write itself triggers
  logic [DATA_W-1:0] word_src;
  logic [CODE_W-1:0] code_sel;
  assign word_src = wr_data ? bus_wdata : data_q;
  assign code_sel = ctrl_q.left_align ? word_src[LA_LSB +: CODE_W] : word_src[CODE_W-1:0];

  logic accept, busy, expire;
  dac_conv_seq #(.CODE_W(CODE_W), .DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig(start_req), .code_in(code_sel),
    .delay(delay_q), .accept(accept), .conv_start(conv_start),
    .conv_code(conv_code), .busy(busy), .expire(expire)
  );

  logic hw_take, udr_set;
  assign hw_take = accept && is_hw && ctrl_q.dma_en;
  assign udr_set = hw_take && dma_pend_q && !wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      data_q     <= '0;
      delay_q    <= DLY_W'(1);
      sw_q       <= 1'b0;
      fin_q      <= 1'b0;
      udr_q      <= 1'b0;
      dma_pend_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_data) data_q  <= bus_wdata;
      if (wr_dly)  delay_q <= bus_wdata[DLY_W-1:0];
      sw_q <= wr_sw && bus_wdata[0];
      if (expire)                            fin_q <= 1'b1;
      else if (wr_stat && bus_wdata[STAT_FIN]) fin_q <= 1'b0;
      if (udr_set)                           udr_q <= 1'b1;
      else if (wr_stat && bus_wdata[STAT_UDR]) udr_q <= 1'b0;
      if (hw_take)      dma_pend_q <= 1'b1;
      else if (wr_data) dma_pend_q <= 1'b0;
    end
  end

  assign dma_req = dma_pend_q;
  assign irq     = (fin_q && ctrl_q.fin_ie) || (udr_q && ctrl_q.udr_ie);

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
      A_DATA:  bus_rdata = data_q;
      A_SWTRG: bus_rdata[0] = sw_q;
      A_STAT: begin
        bus_rdata[STAT_FIN] = fin_q;
        bus_rdata[STAT_UDR] = udr_q;
        bus_rdata[STAT_BSY] = busy;
      end
      A_DELAY: bus_rdata[DLY_W-1:0] = delay_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_finish_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> fin_q);
  assert_sw_selfclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q && !wr_sw) |=> !sw_q);
  assert_udr_needs_open_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udr_q) |-> $past(dma_pend_q));
endmodule

// File: tb/dac_trig_ctrl_bench.sv
module dac_trig_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_pin = 1'b0;
  logic [3:0]  tmr_pulse = '0;
  logic [1:0]  pwm_pulse = '0;
  logic        conv_start;
  logic [11:0] conv_code;
  logic        dma_req, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_trig_ctrl u_dac_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .tmr_pulse(tmr_pulse), .pwm_pulse(pwm_pulse), .conv_start(conv_start),
    .conv_code(conv_code), .dma_req(dma_req), .irq(irq)
  );

  int compared = 0, mismatched = 0, n_conv = 0;
  bit loose = 1'b0, done = 1'b0;
  logic [11:0] expq[$];
  string       tagq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_conv(input string tag, input logic [11:0] code);
    expq.push_back(code); tagq.push_back(tag);
  endtask

  // source index: 0..3 timers, 4..5 PWM
  task automatic pulse(input int idx);
    @(negedge clk);
    if (idx < 4) tmr_pulse[idx] = 1'b1; else pwm_pulse[idx-4] = 1'b1;
    @(negedge clk);
    tmr_pulse = '0; pwm_pulse = '0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      n_conv++;
      if (expq.size() > 0) begin
        logic [11:0] e;
        string t;
        e = expq.pop_front(); t = tagq.pop_front();
        chk(t, {20'd0, conv_code}, {20'd0, e});
      end else if (!loose) begin
        chk("R6 unexpected conversion start", 32'd1, 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    #1 chk("R11 conv_start", {31'd0, conv_start}, 0);
    chk("R11 dma_req", {31'd0, dma_req}, 0);
    chk("R11 irq", {31'd0, irq}, 0);
    rd(3'd0, r); chk("R11 ctrl", r, 0);
    rd(3'd3, r); chk("R11 status", r, 0);
    rd(3'd1, r); chk("R11 data", r, 0);
    rd(3'd2, r); chk("R11 swtrg", r, 0);
    rd(3'd4, r); chk("R11 delay", r, 1);

    // R1 / R5 right alignment, write triggered
    wr(3'd4, 2);
    base = n_conv;
    expect_conv("R5 right align code", 12'h5F7);
    wr(3'd1, 32'hABCD_E5F7);
    chk("R1 start one cycle after write", {31'd0, conv_start}, 1);
    idle(1); chk("R1 start is one cycle", {31'd0, conv_start}, 0);
    idle(3); chk("R1 one conversion", n_conv - base, 1);

    // R5 left alignment
    wr(3'd0, 32'h10);
    expect_conv("R5 left align code", 12'hE5F);
    wr(3'd1, 32'hABCD_E5F7);
    idle(4);

    // R6 busy window and ignored trigger, R7 finish
    wr(3'd0, 0);
    wr(3'd3, 1);
    wr(3'd4, 4);
    base = n_conv;
    expect_conv("R1 write trigger", 12'h011);
    wr(3'd1, 32'h011);
    bus_addr = 3'd3; #1 chk("R6 busy after start", bus_rdata[8], 1);
    wr(3'd1, 32'h022);
    @(negedge clk); bus_addr = 3'd3; #1 chk("R6 busy until count ends", bus_rdata[8], 1);
    chk("R7 finish clear while busy", bus_rdata[0], 0);
    @(negedge clk); #1 chk("R6 idle after D cycles", bus_rdata[8], 0);
    chk("R7 finish set at expiry", bus_rdata[0], 1);
    chk("R6 trigger while busy ignored", n_conv - base, 1);
    rd(3'd1, r); chk("R6 data still stored", r, 32'h022);

    // R7 write one to clear
    wr(3'd3, 0);
    rd(3'd3, r); chk("R7 write 0 keeps finish", r[0], 1);
    wr(3'd3, 1);
    rd(3'd3, r); chk("R7 write 1 clears finish", r[0], 0);

    // R10 finish interrupt
    wr(3'd4, 2);
    wr(3'd0, 32'h1);
    expect_conv("R1 write trigger irq", 12'h005);
    wr(3'd1, 32'h005);
    idle(4); #1 chk("R10 irq from finish", {31'd0, irq}, 1);
    wr(3'd3, 1); #1 chk("R10 irq drops on clear", {31'd0, irq}, 0);

    // R2 software trigger
    wr(3'd0, 32'h2);
    base = n_conv;
    wr(3'd1, 32'h0AA);
    idle(4); chk("R2 data write ignored in trigger mode", n_conv - base, 0);
    expect_conv("R2 software trigger", 12'h0AA);
    wr(3'd2, 1);
    rd(3'd2, r); chk("R2 swtrg self clears", r, 0);
    idle(4); chk("R2 single conversion", n_conv - base, 1);

    // R3 timer / PWM select
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, ((i + 2) << 5) | 32'h2);
      base = n_conv;
      pulse((i + 1) % 6);
      idle(4); chk($sformatf("R3 unselected source %0d ignored", (i + 1) % 6), n_conv - base, 0);
      expect_conv($sformatf("R3 selected source %0d", i), 12'h0AA);
      pulse(i);
      idle(4); chk($sformatf("R3 selected source %0d fires", i), n_conv - base, 1);
    end

    // R4 pin rising edge
    wr(3'd1, 32'h0777);
    wr(3'd0, (3 << 8) | (1 << 5) | 32'h2);
    idle(4);
    base = n_conv;
    expect_conv("R4 rising edge", 12'h777);
    @(negedge clk); ext_pin = 1'b1;
    idle(12); chk("R4 one conversion per rising edge", n_conv - base, 1);
    @(negedge clk); ext_pin = 1'b0;
    idle(8); chk("R4 falling edge ignored in rising mode", n_conv - base, 1);
    // falling edge
    wr(3'd0, (2 << 8) | (1 << 5) | 32'h2);
    idle(4);
    base = n_conv;
    @(negedge clk); ext_pin = 1'b1;
    idle(8); chk("R4 rising edge ignored in falling mode", n_conv - base, 0);
    expect_conv("R4 falling edge", 12'h777);
    @(negedge clk); ext_pin = 1'b0;
    idle(8); chk("R4 one conversion per falling edge", n_conv - base, 1);
    // high level
    wr(3'd0, (1 << 8) | (1 << 5) | 32'h2);
    base = n_conv;
    idle(8); chk("R4 high level idle while low", n_conv - base, 0);
    loose = 1'b1;
    @(negedge clk); ext_pin = 1'b1;
    idle(20);
    @(negedge clk); ext_pin = 1'b0;
    idle(8); loose = 1'b0;
    chk("R4 high level repeats", (n_conv - base) >= 2, 1);
    chk("R4 level code", {20'd0, conv_code}, 32'h777);
    // low level
    @(negedge clk); ext_pin = 1'b1;
    wr(3'd0, (0 << 8) | (1 << 5) | 32'h2);
    base = n_conv;
    idle(8); chk("R4 low level idle while high", n_conv - base, 0);
    loose = 1'b1;
    @(negedge clk); ext_pin = 1'b0;
    idle(20);
    @(negedge clk); ext_pin = 1'b1;
    idle(8); loose = 1'b0;
    chk("R4 low level repeats", (n_conv - base) >= 2, 1);

    // R8 / R9 DMA request and under-run
    wr(3'd3, 3);
    wr(3'd1, 32'h123);
    wr(3'd0, 32'h4E);
    #1 chk("R8 no request before trigger", {31'd0, dma_req}, 0);
    expect_conv("R8 timer with dma", 12'h123);
    pulse(0);
    #1 chk("R8 request raised", {31'd0, dma_req}, 1);
    idle(4);
    rd(3'd3, r); chk("R9 no under-run yet", r[1], 0);
    expect_conv("R9 old code converted again", 12'h123);
    pulse(0);
    idle(4);
    rd(3'd3, r); chk("R9 under-run flag set", r[1], 1);
    #1 chk("R10 irq from under-run", {31'd0, irq}, 1);
    wr(3'd3, 2);
    rd(3'd3, r); chk("R9 under-run cleared", r[1], 0);
    #1 chk("R10 irq drops", {31'd0, irq}, 0);
    wr(3'd1, 32'h456);
    #1 chk("R8 request answered by data write", {31'd0, dma_req}, 0);
    expect_conv("R8 new code after write", 12'h456);
    pulse(0);
    idle(4);
    rd(3'd3, r); chk("R9 no under-run when answered", r[1], 0);
    #1 chk("R8 request raised again", {31'd0, dma_req}, 1);

    chk("R1 scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule